// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host three 8-bit parallel ports, called A, B and C, behind a small register window. The host uses an active-low chip select, active-low read and write strobes, a 2-bit register address and 8-bit write and read data. A configuration byte sets the direction of each port and the operating mode of port B. Port C is treated as two 4-bit halves that can point in different directions. Individual port C bits can be set or cleared with one host write, without a read-modify-write.

Port B has two modes. In the plain mode it is latched output or unlatched input. In the strobed mode it runs a handshake with a peripheral over the low three bits of port C. In that mode bit 0 is the interrupt request and bit 1 is a buffer status flag, and both are outputs. Bit 2 is the peripheral's strobe or acknowledge, and it is an input. Port A always works in the plain mode. Each pin group has separate `in`, `out` and output-enable vectors, and a 1 on an output-enable bit means that pin is driven.

All logic runs on one clock. A host write takes effect at the clock edge during which the chip select and the write strobe are both low. Read data depends only on the present inputs and the state.

Top module: `pport_ctrl`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register. Accesses happen only while `cs_n` is low. `rdata` is 0 whenever no read is active (a read needs `cs_n` and `rd_n` both low).
- R2: After reset the configuration register reads 0x9B, every output-enable bit is 0, and all three ports can be read as inputs with no further programming.
- R3: A write to address 3 with bit 7 set stores the whole byte as the configuration. The byte layout is: bit 0 sets the port C low-half direction, bit 1 the port B direction, bit 2 the port B mode (1 = strobed), bit 3 the port C high-half direction, bit 4 the port A direction, and bits 6:5 the port A mode, which is stored only. For each direction bit, 1 means input. The same write clears all output latches, the handshake flags and the interrupt mask.
- R4: A port set as output drives its latched value on `*_out` with all its enable bits at 1, and a host read of it returns that latch.
- R5: A port set as input is not latched in plain mode: a read returns the pin value present during the read.
- R6: The port C halves are independent. A read of port C returns the latch for each output bit and the pin for each input bit.
- R7: A write to address 3 with bit 7 clear changes one port C latch bit. Bits 3:1 select the bit and bit 0 is its new value.
- R8: In strobed input mode (configuration bits 2 and 1 set), a low level on `pc_in[2]` captures `pb_in`, and `pc_out[1]` (buffer full, 1 = full) goes high. A read of port B returns the captured byte.
- R9: In strobed input mode, `pc_out[0]` (interrupt request) goes high at the rising edge of `pc_in[2]` only if the mask is set. The mask is set by a single-bit write to port C bit 2. The first clock edge of a port B read clears the request, and the end of that read clears buffer full.
- R10: In strobed output mode (configuration bit 2 set, bit 1 clear), a port B write drives `pc_out[1]` low (buffer-full flag, active low) and clears the request. A low on `pc_in[2]` (acknowledge) sets `pc_out[1]` high again, and the acknowledge's rising edge raises the request if the mask is set.
- R11: In strobed mode the port C low-half enables are 1 on bits 0 and 1 and 0 on bit 2, and bit 3 follows configuration bit 0. A read of port C returns the mask on bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is active |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs (bit 2 is strobe/acknowledge in strobed mode) |
| pc_out | output | 8 | Port C outputs, including handshake lines |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench reads port C with its two halves pointing in opposite directions. A design that applied one direction to both halves would return pin values where latch bits were expected. It changes `pb_in` after a strobe and before the read, which catches a port B that passes the live pins through instead of the captured byte. A strobe with the mask clear must leave the interrupt request low. A design that ignored the mask, or did not clear it on a configuration write, would raise the request. The bench also checks the one-cycle gap between the request clearing at the start of a read and buffer full clearing at the end of it.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] SEL_A   = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_B   = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_C   = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CFG = 2'd3;

    // configuration byte bit positions
    localparam int CB_CLO_IN = 0;
    localparam int CB_B_IN   = 1;
    localparam int CB_B_STRB = 2;
    localparam int CB_CHI_IN = 3;
    localparam int CB_A_IN   = 4;
    localparam int CB_DEFINE = 7;

    localparam logic [7:0] CFG_RESET = 8'h9B;

    // port C handshake line positions for port B
    localparam int HS_INTR = 0;
    localparam int HS_FLAG = 1;
    localparam int HS_STB  = 2;
endpackage

// File: rtl/ppc_portb_hs.sv
module ppc_portb_hs #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir_in,
    input  logic          clr,
    input  logic          stb_n,
    input  logic [PW-1:0] pin,
    input  logic          rd_b,
    input  logic          wr_b,
    input  logic          inte_we,
    input  logic          inte_val,
    output logic [PW-1:0] hold,
    output logic          ibf,
    output logic          obf_n,
    output logic          intr,
    output logic          inte
);
    typedef struct packed {
        logic [PW-1:0] hold;
        logic          ibf;
        logic          obf_n;
        logic          intr;
        logic          inte;
        logic          stb_prev;
        logic          rd_prev;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d          = hs_q;
        hs_d.stb_prev = stb_n;
        hs_d.rd_prev  = rd_b;
        if (clr) begin
            hs_d.ibf   = 1'b0;
            hs_d.obf_n = 1'b1;
            hs_d.intr  = 1'b0;
            hs_d.inte  = 1'b0;
        end else if (en) begin
            if (inte_we) hs_d.inte = inte_val;
            if (dir_in) begin
                if (!stb_n) begin
                    hs_d.hold = pin;
                    hs_d.ibf  = 1'b1;
                end
                if (!hs_q.stb_prev && stb_n && hs_q.inte) hs_d.intr = 1'b1;
                if (rd_b) hs_d.intr = 1'b0;
                if (hs_q.rd_prev && !rd_b) hs_d.ibf = 1'b0;
            end else begin
                if (wr_b) begin
                    hs_d.obf_n = 1'b0;
                    hs_d.intr  = 1'b0;
                end
                if (hs_q.stb_prev && !stb_n) hs_d.obf_n = 1'b1;
                if (!hs_q.stb_prev && stb_n && hs_q.inte) hs_d.intr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q          <= '0;
            hs_q.obf_n    <= 1'b1;
            hs_q.stb_prev <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hold  = hs_q.hold;
    assign ibf   = hs_q.ibf;
    assign obf_n = hs_q.obf_n;
    assign intr  = hs_q.intr;
    assign inte  = hs_q.inte;

    // R8: buffer full only rises after a low strobe was seen
    a_r8_full_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q.ibf) |-> $past(!stb_n));
    // R9: request only rises while the mask was set
    a_r9_intr_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q.intr) |-> $past(hs_q.inte));
    // R10: output flag only drops after a host write to port B
    a_r10_flag_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_q.obf_n) |-> $past(wr_b));
    // R3: configuration write clears the handshake state
    a_r3_define_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!hs_q.inte && !hs_q.intr && !hs_q.ibf && hs_q.obf_n));
endmodule

// File: rtl/ppc_rdmux.sv
module ppc_rdmux
    import ppc_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cfg,
    input  logic [PW-1:0]     pa_in,
    input  logic [PW-1:0]     pa_lat,
    input  logic [PW-1:0]     pb_in,
    input  logic [PW-1:0]     pb_lat,
    input  logic [PW-1:0]     pb_hold,
    input  logic [PW-1:0]     pc_in,
    input  logic [PW-1:0]     pc_drv,
    input  logic [PW-1:0]     pc_en,
    input  logic              inte,
    output logic [PW-1:0]     rdata
);
    logic [PW-1:0] pc_view;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            pc_view[i] = pc_en[i] ? pc_drv[i] : pc_in[i];
        end
        if (cfg[CB_B_STRB]) pc_view[HS_STB] = inte;
    end

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (addr)
                SEL_A:   rdata = cfg[CB_A_IN] ? pa_in : pa_lat;
                SEL_B:   rdata = cfg[CB_B_IN] ? (cfg[CB_B_STRB] ? pb_hold : pb_in) : pb_lat;
                SEL_C:   rdata = pc_view;
                default: rdata = PW'(cfg);
            endcase
        end
    end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import ppc_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [PW-1:0]     rdata,
    input  logic [PW-1:0]     pa_in,
    output logic [PW-1:0]     pa_out,
    output logic [PW-1:0]     pa_oe,
    input  logic [PW-1:0]     pb_in,
    output logic [PW-1:0]     pb_out,
    output logic [PW-1:0]     pb_oe,
    input  logic [PW-1:0]     pc_in,
    output logic [PW-1:0]     pc_out,
    output logic [PW-1:0]     pc_oe
);
    localparam int HW = PW / 2;
    localparam int IW = $clog2(PW);

    typedef struct packed {
        logic [7:0]    cfg;
        logic [PW-1:0] pa_lat;
        logic [PW-1:0] pb_lat;
        logic [PW-1:0] pc_lat;
    } st_t;

    st_t st_d, st_q;

    logic wr_act, rd_act, def_we, bit_we;
    logic [PW-1:0] pb_hold;
    logic ibf, obf_n, intr, inte;
    logic strobed;

    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n;
    assign def_we  = wr_act && (addr == SEL_CFG) && wdata[CB_DEFINE];
    assign bit_we  = wr_act && (addr == SEL_CFG) && !wdata[CB_DEFINE];
    assign strobed = st_q.cfg[CB_B_STRB];

    always_comb begin
        st_d = st_q;
        if (def_we) begin
            st_d.cfg    = wdata;
            st_d.pa_lat = '0;
            st_d.pb_lat = '0;
            st_d.pc_lat = '0;
        end else if (bit_we) begin
            st_d.pc_lat[wdata[IW:1]] = wdata[0];
        end else if (wr_act) begin
            unique case (addr)
                SEL_A:   st_d.pa_lat = wdata[PW-1:0];
                SEL_B:   st_d.pb_lat = wdata[PW-1:0];
                SEL_C:   st_d.pc_lat = wdata[PW-1:0];
                default: st_d.pc_lat = st_q.pc_lat;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    ppc_portb_hs #(.PW(PW)) hs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (strobed),
        .dir_in   (st_q.cfg[CB_B_IN]),
        .clr      (def_we),
        .stb_n    (pc_in[HS_STB]),
        .pin      (pb_in),
        .rd_b     (rd_act && (addr == SEL_B)),
        .wr_b     (wr_act && (addr == SEL_B)),
        .inte_we  (bit_we && (wdata[IW:1] == IW'(HS_STB))),
        .inte_val (wdata[0]),
        .hold     (pb_hold),
        .ibf      (ibf),
        .obf_n    (obf_n),
        .intr     (intr),
        .inte     (inte)
    );

    assign pa_out = st_q.pa_lat;
    assign pa_oe  = {PW{!st_q.cfg[CB_A_IN]}};
    assign pb_out = st_q.pb_lat;
    assign pb_oe  = {PW{!st_q.cfg[CB_B_IN]}};

    always_comb begin
        pc_out = st_q.pc_lat;
        pc_oe  = {{HW{!st_q.cfg[CB_CHI_IN]}}, {HW{!st_q.cfg[CB_CLO_IN]}}};
        if (strobed) begin
            pc_out[HS_INTR] = intr;
            pc_out[HS_FLAG] = st_q.cfg[CB_B_IN] ? ibf : obf_n;
            pc_oe[HS_INTR]  = 1'b1;
            pc_oe[HS_FLAG]  = 1'b1;
            pc_oe[HS_STB]   = 1'b0;
        end
    end

    ppc_rdmux #(.PW(PW)) rd_i (
        .rd_act  (rd_act),
        .addr    (addr),
        .cfg     (st_q.cfg),
        .pa_in   (pa_in),
        .pa_lat  (st_q.pa_lat),
        .pb_in   (pb_in),
        .pb_lat  (st_q.pb_lat),
        .pb_hold (pb_hold),
        .pc_in   (pc_in),
        .pc_drv  (pc_out),
        .pc_en   (pc_oe),
        .inte    (inte),
        .rdata   (rdata)
    );

    // R1: no read, no data on the host bus
    always_comb begin
        if (rst_n && !rd_act) begin
            a_r1_idle_bus_zero: assert (rdata == '0);
        end
    end

    // R3: a configuration write empties every output latch
    a_r3_define_clears_latches: assert property (@(posedge clk) disable iff (!rst_n)
        def_we |=> (pa_out == '0 && pb_out == '0));
    // R11: strobe line is never driven in strobed mode
    a_r11_strobe_pin_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        strobed |-> !pc_oe[HS_STB]);
endmodule

// File: tb/pport_ctrl_tb_top.sv
module pport_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h04;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #5 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // entry: {write, addr, data or expected read, pin value on all ports}
    localparam int NV = 24;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 2'd3, 8'h80, 8'h00},   // all outputs
        {1'b1, 2'd0, 8'h5A, 8'h00},
        {1'b0, 2'd0, 8'h5A, 8'h00},   // R4
        {1'b1, 2'd1, 8'hC3, 8'h00},
        {1'b0, 2'd1, 8'hC3, 8'h00},   // R4
        {1'b1, 2'd2, 8'h96, 8'h00},
        {1'b0, 2'd2, 8'h96, 8'h00},   // R4
        {1'b0, 2'd3, 8'h80, 8'h00},   // R3 readback
        {1'b1, 2'd3, 8'h90, 8'h3C},   // A input
        {1'b0, 2'd0, 8'h3C, 8'h3C},   // R5
        {1'b0, 2'd1, 8'h00, 8'h3C},   // R3 latch cleared
        {1'b0, 2'd2, 8'h00, 8'h3C},   // R3 latch cleared
        {1'b1, 2'd3, 8'h88, 8'hA5},   // C high half input
        {1'b1, 2'd2, 8'h0F, 8'hA5},
        {1'b0, 2'd2, 8'hAF, 8'hA5},   // R6
        {1'b1, 2'd3, 8'h81, 8'h5A},   // C low half input
        {1'b0, 2'd2, 8'h0A, 8'h5A},   // R6
        {1'b1, 2'd3, 8'h80, 8'h00},
        {1'b1, 2'd3, 8'h0B, 8'h00},   // set bit 5
        {1'b0, 2'd2, 8'h20, 8'h00},   // R7
        {1'b1, 2'd3, 8'h07, 8'h00},   // set bit 3
        {1'b0, 2'd2, 8'h28, 8'h00},   // R7
        {1'b1, 2'd3, 8'h0A, 8'h00},   // clear bit 5
        {1'b0, 2'd2, 8'h08, 8'h00}    // R7
    };

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        @(negedge clk);
        check("R2 oe", pa_oe | pb_oe | pc_oe, 8'h00);
        bus_read(2'd3, rd);
        check("R2 cfg", rd, 8'h9B);
        pa_in = 8'h77;
        bus_read(2'd0, rd);
        check("R2 port A input", rd, 8'h77);

        // R1: read strobe without chip select
        @(negedge clk);
        addr = 2'd3; rd_n = 1'b0;
        #5 check("R1 deselected", rdata, 8'h00);
        @(negedge clk);
        rd_n = 1'b1;

        // R1: write without chip select is ignored
        @(negedge clk);
        addr = 2'd3; wdata = 8'h80; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        bus_read(2'd3, rd);
        check("R1 ignored write", rd, 8'h9B);

        for (int i = 0; i < NV; i++) begin
            pa_in = VEC[i][7:0];
            pb_in = VEC[i][7:0];
            pc_in = VEC[i][7:0];
            if (VEC[i][18]) begin
                bus_write(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][17:16], rd);
                check($sformatf("vector %0d", i), rd, VEC[i][15:8]);
            end
        end

        // R3 / R4: directions follow the configuration byte
        bus_write(2'd3, 8'h80);
        @(negedge clk);
        check("R3 A oe", pa_oe, 8'hFF);
        check("R4 C oe", pc_oe, 8'hFF);

        // R8 / R9 / R11: strobed input
        pc_in = 8'h04;
        bus_write(2'd3, 8'h86);
        @(negedge clk);
        check("R11 C oe", pc_oe, 8'hFB);
        check("R8 full idle", {7'd0, pc_out[1]}, 8'h00);
        pb_in = 8'h3E; pc_in[2] = 1'b0;
        @(negedge clk);
        pc_in[2] = 1'b1;
        @(negedge clk);
        check("R8 full set", {7'd0, pc_out[1]}, 8'h01);
        check("R9 no mask no request", {7'd0, pc_out[0]}, 8'h00);
        pb_in = 8'h00;
        bus_read(2'd1, rd);
        check("R8 captured", rd, 8'h3E);
        @(negedge clk);
        check("R9 full cleared", {7'd0, pc_out[1]}, 8'h00);

        bus_write(2'd3, 8'h05);   // mask on via bit 2
        bus_read(2'd2, rd);
        check("R11 mask readback", rd & 8'h04, 8'h04);
        pb_in = 8'h71; pc_in[2] = 1'b0;
        @(negedge clk);
        check("R9 no request while low", {7'd0, pc_out[0]}, 8'h00);
        pc_in[2] = 1'b1;
        @(negedge clk);
        check("R9 request", {7'd0, pc_out[0]}, 8'h01);
        bus_read(2'd1, rd);
        check("R8 captured 2", rd, 8'h71);
        check("R9 request cleared", {7'd0, pc_out[0]}, 8'h00);
        check("R9 full held", {7'd0, pc_out[1]}, 8'h01);
        @(negedge clk);
        check("R9 full cleared at end", {7'd0, pc_out[1]}, 8'h00);

        // R10: strobed output; R3 mask cleared by new configuration
        bus_write(2'd3, 8'h84);
        bus_read(2'd2, rd);
        check("R3 mask cleared", rd & 8'h04, 8'h00);
        check("R10 flag idle", {7'd0, pc_out[1]}, 8'h01);
        bus_write(2'd3, 8'h05);
        bus_write(2'd1, 8'h99);
        check("R10 flag low", {7'd0, pc_out[1]}, 8'h00);
        check("R10 data", pb_out, 8'h99);
        pc_in[2] = 1'b0;
        @(negedge clk);
        check("R10 flag released", {7'd0, pc_out[1]}, 8'h01);
        check("R10 no request yet", {7'd0, pc_out[0]}, 8'h00);
        pc_in[2] = 1'b1;
        @(negedge clk);
        check("R10 request", {7'd0, pc_out[0]}, 8'h01);
        bus_write(2'd1, 8'h12);
        check("R10 request cleared", {7'd0, pc_out[0]}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule